// File: doc/BRIEF.md
# Invalid Block Table Builder

This engine surveys a small NAND array right after reset and records which erase blocks can be used. The array has 128 blocks. Each block holds 32 rows of 128 bytes, and each row is four 32-byte frames. A block that left the factory defective carries a non-erased byte at the start of its first or second row. Every other location ships erased, reading FFh. The engine walks the blocks in ascending order from block 0. For each block it reads the first byte of row 0 and then of row 1 through a simple request/response port to a lower-level flash reader. It keeps one bit per block in an internal map.

The first block is guaranteed usable, so it is never marked. While the survey runs, `busy_o` stays high and every lookup reports the block as unusable. When the last response has been taken in, `done_o` pulses once. Other logic can retire a block at any time, for example after a failed program or erase, by presenting its number on the mark input.

A running count of retired blocks is kept. The device promises at most three bad blocks, so a sticky error flag rises when the count goes above that limit.

Top module: `ibt_builder`

## Requirements
- R1: After reset is released, `busy_o` is 1, `done_o` is 0, `bad_cnt_o` is 0 and `err_o` is 0. A read request for address 0 is presented at once, with no start command needed.
- R2: The read address is {block[6:0], row[4:0], 2'b00, 5'b00000}. Requests go row 0 then row 1 for each block, blocks 0 to 127 in ascending order, 256 requests in all. A new request is not raised until the response to the previous one has arrived.
- R3: A block other than block 0 is recorded unusable when either of its two returned bytes differs from FFh. Any value other than FFh counts, not only 00h.
- R4: Block 0 always looks up as usable after the survey, whatever its bytes hold and whether or not it is marked.
- R5: `done_o` is high for exactly one cycle. That cycle is the one after the clock edge that accepts the final response. `busy_o` is 0 from that same cycle on.
- R6: While `busy_o` is 1, `lk_ok_o` is 0 for every block. Afterwards, `lk_ok_o` is 1 exactly when the block looked up has not been recorded unusable.
- R7: A one-cycle pulse on `mark_valid_i` records `mark_blk_i` as unusable from the next cycle. This also works during the survey, and the survey does not clear it. Marking block 0, or a block already recorded, leaves the map and the count unchanged.
- R8: `bad_cnt_o` equals the number of distinct blocks recorded unusable. `err_o` becomes 1 once the count exceeds 3 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; starts a new survey when released |
| rd_req_o | output | 1 | Read request to the flash reader, one cycle per request |
| rd_addr_o | output | 19 | Byte address of the requested read |
| rd_rsp_valid_i | input | 1 | Response strobe from the flash reader |
| rd_rsp_data_i | input | 8 | Byte returned with the response |
| lk_blk_i | input | 7 | Block number to look up |
| lk_ok_o | output | 1 | 1 when the looked-up block is usable and the survey is over |
| mark_valid_i | input | 1 | Retire the block on `mark_blk_i` |
| mark_blk_i | input | 7 | Block to retire |
| busy_o | output | 1 | Survey in progress |
| done_o | output | 1 | One-cycle pulse when the survey completes |
| bad_cnt_o | output | 8 | Number of blocks recorded unusable |
| err_o | output | 1 | Sticky flag: more than 3 unusable blocks |

## Verification
The hardest case to reach is a runtime retirement that lands in the middle of the survey. The mark must survive the survey's own later writes and be counted exactly once. The bench modelled flash reader answers with delays that cycle through one to three cycles, which keeps the engine's wait state busy. A pulse on the mark input is then injected partway through the survey. The full map is swept afterwards for every block. A second pattern places several marker values, including non-zero ones, so that the count crosses the threshold and the error flag rises.

// File: rtl/ibt_pkg.sv
package ibt_pkg;

    typedef enum logic [1:0] {
        SC_REQ,
        SC_WAIT,
        SC_IDLE
    } scan_st_e;

endpackage

// File: rtl/ibt_scan.sv
module ibt_scan
    import ibt_pkg::*;
#(
    parameter int          BLK_W    = 7,
    parameter int          ROW_W    = 5,
    parameter int          FRAME_W  = 2,
    parameter int          COL_W    = 5,
    parameter int          CHK_ROWS = 2,
    parameter logic [7:0]  ERASED   = 8'hFF,
    parameter int          ADDR_W   = BLK_W + ROW_W + FRAME_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_rsp_valid_i,
    input  logic [7:0]        rd_rsp_data_i,
    output logic              rec_valid_o,
    output logic              rec_bad_o,
    output logic [BLK_W-1:0]  rec_blk_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int             PG_W     = (CHK_ROWS > 1) ? $clog2(CHK_ROWS) : 1;
    localparam logic [BLK_W-1:0] LAST_BLK = {BLK_W{1'b1}};
    localparam logic [PG_W-1:0]  LAST_PG  = PG_W'(CHK_ROWS - 1);

    typedef struct packed {
        scan_st_e         st;
        logic [BLK_W-1:0] blk;
        logic [PG_W-1:0]  pg;
        logic             bad;
        logic             done;
    } scan_t;

    scan_t s_d, s_q;
    logic  hit;

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        rec_valid_o = 1'b0;
        rec_bad_o   = 1'b0;
        hit         = s_q.bad | (rd_rsp_data_i != ERASED);
        case (s_q.st)
            SC_REQ: s_d.st = SC_WAIT;
            SC_WAIT: begin
                if (rd_rsp_valid_i) begin
                    if (s_q.pg == LAST_PG) begin
                        rec_valid_o = 1'b1;
                        rec_bad_o   = hit;
                        s_d.pg      = '0;
                        s_d.bad     = 1'b0;
                        if (s_q.blk == LAST_BLK) begin
                            s_d.st   = SC_IDLE;
                            s_d.done = 1'b1;
                        end else begin
                            s_d.blk = s_q.blk + 1'b1;
                            s_d.st  = SC_REQ;
                        end
                    end else begin
                        s_d.pg  = s_q.pg + 1'b1;
                        s_d.bad = hit;
                        s_d.st  = SC_REQ;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SC_REQ, blk: '0, pg: '0, bad: 1'b0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_req_o  = (s_q.st == SC_REQ);
    assign rd_addr_o = {s_q.blk, ROW_W'(s_q.pg), {FRAME_W{1'b0}}, {COL_W{1'b0}}};
    assign rec_blk_o = s_q.blk;
    assign busy_o    = (s_q.st != SC_IDLE);
    assign done_o    = s_q.done;

endmodule

// File: rtl/ibt_bitmap.sv
module ibt_bitmap #(
    parameter int BLK_W   = 7,
    parameter int MAX_BAD = 3,
    parameter int CNT_W   = BLK_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_valid_i,
    input  logic             rec_bad_i,
    input  logic [BLK_W-1:0] rec_blk_i,
    input  logic             mark_valid_i,
    input  logic [BLK_W-1:0] mark_blk_i,
    input  logic             busy_i,
    input  logic [BLK_W-1:0] lk_blk_i,
    output logic             lk_ok_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             err_o
);

    localparam int NBLK = 1 << BLK_W;

    typedef struct packed {
        logic [NBLK-1:0]  tbl;
        logic [CNT_W-1:0] cnt;
        logic             err;
    } map_t;

    map_t m_d, m_q;
    logic rec_new, mark_new;
    logic [NBLK-1:0] set_v;

    always_comb begin
        m_d      = m_q;
        rec_new  = rec_valid_i && rec_bad_i && (rec_blk_i != '0)
                   && !m_q.tbl[rec_blk_i];
        mark_new = mark_valid_i && (mark_blk_i != '0) && !m_q.tbl[mark_blk_i]
                   && !(rec_new && (mark_blk_i == rec_blk_i));
        for (int i = 0; i < NBLK; i++) begin
            set_v[i] = (rec_new && (rec_blk_i == BLK_W'(i)))
                     || (mark_new && (mark_blk_i == BLK_W'(i)));
        end
        m_d.tbl = m_q.tbl | set_v;
        m_d.cnt = m_q.cnt + CNT_W'(rec_new) + CNT_W'(mark_new);
        m_d.err = m_q.err | (m_d.cnt > CNT_W'(MAX_BAD));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign lk_ok_o = !busy_i && !m_q.tbl[lk_blk_i];
    assign cnt_o   = m_q.cnt;
    assign err_o   = m_q.err;

endmodule

// File: rtl/ibt_builder.sv
module ibt_builder #(
    parameter int BLK_W    = 7,
    parameter int ROW_W    = 5,
    parameter int FRAME_W  = 2,
    parameter int COL_W    = 5,
    parameter int CHK_ROWS = 2,
    parameter int MAX_BAD  = 3,
    parameter int ADDR_W   = BLK_W + ROW_W + FRAME_W + COL_W,
    parameter int CNT_W    = BLK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_rsp_valid_i,
    input  logic [7:0]        rd_rsp_data_i,
    input  logic [BLK_W-1:0]  lk_blk_i,
    output logic              lk_ok_o,
    input  logic              mark_valid_i,
    input  logic [BLK_W-1:0]  mark_blk_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  bad_cnt_o,
    output logic              err_o
);

    logic             rec_valid;
    logic             rec_bad;
    logic [BLK_W-1:0] rec_blk;

    ibt_scan #(
        .BLK_W    (BLK_W),
        .ROW_W    (ROW_W),
        .FRAME_W  (FRAME_W),
        .COL_W    (COL_W),
        .CHK_ROWS (CHK_ROWS),
        .ERASED   (8'hFF),
        .ADDR_W   (ADDR_W)
    ) u_scan (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_req_o       (rd_req_o),
        .rd_addr_o      (rd_addr_o),
        .rd_rsp_valid_i (rd_rsp_valid_i),
        .rd_rsp_data_i  (rd_rsp_data_i),
        .rec_valid_o    (rec_valid),
        .rec_bad_o      (rec_bad),
        .rec_blk_o      (rec_blk),
        .busy_o         (busy_o),
        .done_o         (done_o)
    );

    ibt_bitmap #(
        .BLK_W   (BLK_W),
        .MAX_BAD (MAX_BAD),
        .CNT_W   (CNT_W)
    ) u_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .rec_valid_i  (rec_valid),
        .rec_bad_i    (rec_bad),
        .rec_blk_i    (rec_blk),
        .mark_valid_i (mark_valid_i),
        .mark_blk_i   (mark_blk_i),
        .busy_i       (busy_o),
        .lk_blk_i     (lk_blk_i),
        .lk_ok_o      (lk_ok_o),
        .cnt_o        (bad_cnt_o),
        .err_o        (err_o)
    );

endmodule

// File: rtl/ibt_checker.sv
module ibt_checker #(
    parameter int BLK_W    = 7,
    parameter int ROW_W    = 5,
    parameter int FRAME_W  = 2,
    parameter int COL_W    = 5,
    parameter int CHK_ROWS = 2,
    parameter int MAX_BAD  = 3,
    parameter int ADDR_W   = BLK_W + ROW_W + FRAME_W + COL_W,
    parameter int CNT_W    = BLK_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_rsp_valid_i,
    input logic [BLK_W-1:0]  lk_blk_i,
    input logic              lk_ok_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [CNT_W-1:0]  bad_cnt_o,
    input logic              err_o
);

    localparam int LOW_W = FRAME_W + COL_W;

    logic outst_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outst_q <= 1'b0;
        end else if (rd_req_o) begin
            outst_q <= 1'b1;
        end else if (rd_rsp_valid_i) begin
            outst_q <= 1'b0;
        end
    end

    p_addr_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_addr_o[LOW_W-1:0] == '0)
                  && (rd_addr_o[ROW_W+LOW_W-1:LOW_W] < ROW_W'(CHK_ROWS)));

    p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> !outst_q);

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_no_req_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_req_o);

    p_lookup_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !lk_ok_o);

    p_block0_usable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && lk_blk_i == '0) |-> lk_ok_o);

    p_count_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bad_cnt_o >= $past(bad_cnt_o)));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    p_err_threshold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_cnt_o > CNT_W'(MAX_BAD)) |-> err_o);

endmodule

bind ibt_builder ibt_checker #(
    .BLK_W    (BLK_W),
    .ROW_W    (ROW_W),
    .FRAME_W  (FRAME_W),
    .COL_W    (COL_W),
    .CHK_ROWS (CHK_ROWS),
    .MAX_BAD  (MAX_BAD),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_req_o       (rd_req_o),
    .rd_addr_o      (rd_addr_o),
    .rd_rsp_valid_i (rd_rsp_valid_i),
    .lk_blk_i       (lk_blk_i),
    .lk_ok_o        (lk_ok_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .bad_cnt_o      (bad_cnt_o),
    .err_o          (err_o)
);

// File: tb/ibt_builder_test.sv
`timescale 1ns/1ps
module ibt_builder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req;
    logic [18:0] rd_addr;
    logic        rsp_v = 1'b0;
    logic [7:0]  rsp_d = 8'hFF;
    logic [6:0]  lk_b = '0;
    logic        lk_ok;
    logic        mark_v = 1'b0;
    logic [6:0]  mark_b = '0;
    logic        busy, done;
    logic [7:0]  bad_cnt;
    logic        err;

    int n_tests = 0;
    int n_fail  = 0;
    int scn     = 0;
    int req_idx = 0;
    int addr_err = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ibt_builder uut (
        .clk(clk), .rst_n(rst_n),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr),
        .rd_rsp_valid_i(rsp_v), .rd_rsp_data_i(rsp_d),
        .lk_blk_i(lk_b), .lk_ok_o(lk_ok),
        .mark_valid_i(mark_v), .mark_blk_i(mark_b),
        .busy_o(busy), .done_o(done),
        .bad_cnt_o(bad_cnt), .err_o(err)
    );

    function automatic logic [7:0] flash_byte(int s, int b, int row);
        if (s == 1) begin
            if (b == 0 && row == 0)   return 8'h00;
            if (b == 5 && row == 0)   return 8'h00;
            if (b == 77 && row == 1)  return 8'h00;
            if (b == 127 && row == 0) return 8'h7F;
        end else if (s == 2) begin
            if (b == 0 && row == 1)                 return 8'h00;
            if ((b % 25) == 3 && row == (b & 1))    return 8'h00;
        end
        return 8'hFF;
    endfunction

    function automatic bit scan_bad(int s, int b);
        return (b != 0) && (flash_byte(s, b, 0) != 8'hFF || flash_byte(s, b, 1) != 8'hFF);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // modelled flash reader: answers each request after 1..3 cycles
    initial begin
        int b, r, d;
        @(negedge clk);
        forever begin
            if (rst_n && rd_req) begin
                b = req_idx / 2;
                r = req_idx % 2;
                if (rd_addr !== 19'((b << 12) | (r << 7))) addr_err++;
                d = 1 + (req_idx % 3);
                req_idx++;
                repeat (d) @(negedge clk);
                rsp_v = 1'b1;
                rsp_d = flash_byte(scn, b, r);
                @(negedge clk);
                rsp_v = 1'b0;
                rsp_d = 8'hFF;
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic do_reset(int s);
        rst_n = 1'b0;
        mark_v = 1'b0;
        lk_b = '0;
        scn = s;
        repeat (3) @(negedge clk);
        req_idx = 0;
        addr_err = 0;
        @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
    endtask

    // waits for the end of the survey; optional mark pulse at cycle mark_at
    task automatic run_scan(int mark_at, int mblk);
        int cyc = 0;
        int busy_drop = 0;
        while (!done && cyc < 5000) begin
            if (cyc == 20) begin
                lk_b = 7'd3;
                #1 chk(lk_ok == 1'b0, "R6 lookup while busy", lk_ok, 0);
            end
            if (cyc == mark_at) begin
                mark_b = 7'(mblk);
                mark_v = 1'b1;
            end else begin
                mark_v = 1'b0;
            end
            if (!busy) busy_drop++;
            @(negedge clk);
            cyc++;
        end
        mark_v = 1'b0;
        chk(done == 1'b1, "R5 done seen", done, 1);
        chk(busy == 1'b0, "R5 busy low with done", busy, 0);
        chk(busy_drop == 0, "R5 busy held during survey", busy_drop, 0);
        chk(addr_err == 0, "R2 address order", addr_err, 0);
        chk(req_idx == 256, "R2 request total", req_idx, 256);
        @(negedge clk);
        chk(done == 1'b0, "R5 done one cycle", done, 0);
    endtask

    task automatic sweep(int extra);
        int mism = 0;
        bit exp;
        for (int b = 0; b < 128; b++) begin
            lk_b = 7'(b);
            #1;
            exp = !(scan_bad(scn, b) || b == extra);
            if (lk_ok !== exp) begin
                mism++;
                chk(1'b0, (b == 0) ? "R4 block0 lookup" : "R3/R6 lookup", lk_ok, exp);
            end
        end
        chk(mism == 0, "R3 map sweep", mism, 0);
    endtask

    task automatic mark(int b);
        mark_b = 7'(b);
        mark_v = 1'b1;
        @(negedge clk);
        mark_v = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int exp_cnt;
        // scenario 0: all erased
        do_reset(0);
        chk(busy == 1'b1, "R1 busy after reset", busy, 1);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(bad_cnt == 0, "R1 count after reset", bad_cnt, 0);
        chk(err == 1'b0, "R1 err after reset", err, 0);
        chk(rd_req == 1'b1 && rd_addr == 0, "R1 first request", rd_addr, 0);
        run_scan(-1, 0);
        sweep(-1);
        chk(bad_cnt == 0, "R8 count clean", bad_cnt, 0);
        chk(err == 1'b0, "R8 err clean", err, 0);

        // scenario 1: three marked blocks, block 0 marked too
        do_reset(1);
        run_scan(-1, 0);
        sweep(-1);
        chk(bad_cnt == 3, "R3 count of three", bad_cnt, 3);
        chk(err == 1'b0, "R8 err at limit", err, 0);
        mark(0);
        lk_b = 0; #1;
        chk(lk_ok == 1'b1, "R4 mark block0 ignored", lk_ok, 1);
        chk(bad_cnt == 3, "R7 count after block0 mark", bad_cnt, 3);
        mark(5);
        chk(bad_cnt == 3, "R7 repeat mark no count", bad_cnt, 3);
        lk_b = 9; #1;
        chk(lk_ok == 1'b1, "R7 block9 before mark", lk_ok, 1);
        mark(9);
        lk_b = 9; #1;
        chk(lk_ok == 1'b0, "R7 block9 retired", lk_ok, 0);
        chk(bad_cnt == 4, "R8 count after mark", bad_cnt, 4);
        chk(err == 1'b1, "R8 err over limit", err, 1);
        repeat (5) @(negedge clk);
        chk(err == 1'b1, "R8 err sticky", err, 1);

        // scenario 2: five marked blocks plus a retirement mid-survey
        do_reset(2);
        run_scan(300, 10);
        sweep(10);
        exp_cnt = 0;
        for (int b = 0; b < 128; b++) if (scan_bad(2, b) || b == 10) exp_cnt++;
        chk(bad_cnt == 8'(exp_cnt), "R7 mid-survey mark kept", bad_cnt, exp_cnt);
        chk(err == 1'b1, "R8 err from survey", err, 1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule